// File: doc/BRIEF.md
# Pixel Hit Timing and Counting Logic

This block is the digital part of one detector pixel. It turns a discriminator output into a stored measurement, and it has two modes. In time mode it records three values for the first hit: a fine arrival bin counted on a local fast clock, a coarse arrival count on the system clock that runs until a shared stop trigger, and a time-over-threshold count. In counting mode it counts hit rising edges. A mask bit in the configuration turns the pixel off.

Every counter is a linear feedback shift register (LFSR) while data is taken. When the trigger has ended acquisition, the three registers act together as one 24-bit shift register. A token read-out passes through a column of pixels. A pixel that holds data shifts its word out serially and then forwards the token. A pixel with no data forwards the token straight away. Only a reset returns the pixel to acquisition.

The fast oscillator is modelled as a free-running input clock that runs 16 times faster than the system clock. The pixel counts its edges only while a measurement window is open.

Top module: `pixelHitTimer`

## Requirements
- R1: After reset, tokenOut and serValid are low. All three fields start at the value 1. A time-mode hit whose fine, ToT and coarse counters never step reads out as the word 0x001011.
- R2: The fine field is a 4-bit LFSR with next = {s[2:0], s[3]^s[2]}. It steps once on each fast-clock rising edge that follows the fast edge first seeing the hit, up to the last fast edge before the system clock edge that records the hit.
- R3: The coarse field is a 12-bit LFSR with next = {s[10:0], s[11]^s[5]^s[3]^s[0]}. In time mode it steps on each system clock edge after the recording edge and before the trigger edge. For a trigger sampled K edges after the recording edge, that gives K-1 steps.
- R4: The ToT field is an 8-bit LFSR with next = {s[6:0], s[7]^s[5]^s[4]^s[3]}. It steps on each clock edge after the recording edge while hit is still high. It stops for good at the first edge that sees hit low, and it also stops at the trigger.
- R5: A hit first seen on the same clock edge that samples the trigger is not recorded. The pixel then reads out as having no data.
- R6: In counting mode the coarse field steps once for every hit rising edge seen on the system clock. The ToT and fine fields stay at 1.
- R7: In counting mode the count saturates at 0x800, the state that precedes the seed. Any further hits leave it at 0x800.
- R8: With the mask bit set, no hit is recorded in either mode.
- R9: If the token is sampled high after the trigger and data is present, the 24-bit word {coarse, ToT, fine} goes out MSB first on serData. One bit is sent per clock, with serValid high, starting the cycle after the token is sampled. tokenOut rises in the 25th cycle.
- R10: If the token is sampled high after the trigger and no data is present, tokenOut rises in the next cycle and serValid stays low.
- R11: A token that arrives before the trigger is ignored: tokenOut and serValid stay low.
- R12: Hits that arrive after the trigger or during read-out change neither the stored word nor the data-present decision, until reset.
- R13: In time mode only the first hit is measured. A later hit before the trigger does not restart ToT and does not alter the fine or coarse values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (coarse) clock |
| fastClk | input | 1 | Local fast oscillator, 16 times the system clock |
| rst | input | 1 | Synchronous active-high reset of all pixel state |
| hit | input | 1 | Discriminator output |
| trigger | input | 1 | Common stop shared by all pixels |
| tokenIn | input | 1 | Read-out token from the previous pixel |
| cfgMask | input | 1 | 1 suppresses all hits |
| cfgCountMode | input | 1 | 1 selects hit counting, 0 selects time measurement |
| serData | output | 1 | Serial read-out data, MSB first |
| serValid | output | 1 | High while serData carries a word bit |
| tokenOut | output | 1 | Token to the next pixel |

## Verification
The recording of a first hit and the common stop can land on the same system clock edge. There the trigger must win and the pixel must report no data. The bench produces this case in two ways. In one, the hit rises just before the trigger edge, after the last fast edge. In the other, the fast counter has already started a few nanoseconds earlier. In both cases it judges the result at the ports: the token comes back after one cycle and serValid never rises. The same stimulus with the trigger one edge later must give the all-seed word.

// File: rtl/pixelTimerPkg.sv
`timescale 1ns/1ps
package pixelTimerPkg;
  localparam int COARSE_W_D = 12;
  localparam int TOT_W_D    = 8;
  localparam int FINE_W_D   = 4;

  // feedback masks: bit i set means state bit i enters the XOR
  localparam logic [COARSE_W_D-1:0] COARSE_TAPS_D = 12'h829;
  localparam logic [TOT_W_D-1:0]    TOT_TAPS_D    = 8'hB8;
  localparam logic [FINE_W_D-1:0]   FINE_TAPS_D   = 4'hC;

  typedef enum logic [1:0] {
    PX_ACQ,
    PX_HELD,
    PX_SHIFT,
    PX_PASSED
  } pxState_t;

  typedef struct packed {
    logic coarseStep;
    logic countStep;
    logic totStep;
    logic shiftStep;
  } pxStrobe_t;
endpackage

// File: rtl/pixelFineCounter.sv
`timescale 1ns/1ps
module pixelFineCounter #(
  parameter int            FINE_W = 4,
  parameter logic [FINE_W-1:0] FINE_TAPS = 4'hC
) (
  input  logic              fastClk,
  input  logic              rst,
  input  logic              hit,
  input  logic              arm,
  input  logic              stop,
  output logic              started,
  output logic [FINE_W-1:0] value
);
  localparam logic [FINE_W-1:0] SEED = FINE_W'(1);

  logic              startedQ;
  logic [FINE_W-1:0] valQ;

  always_ff @(posedge fastClk) begin
    if (rst) begin
      startedQ <= 1'b0;
      valQ     <= SEED;
    end else if (!startedQ) begin
      if (arm && hit) startedQ <= 1'b1;
    end else if (!stop) begin
      valQ <= {valQ[FINE_W-2:0], ^(valQ & FINE_TAPS)};
    end
  end

  assign started = startedQ;
  assign value   = valQ;

  // R2: once the window is closed the fine value no longer moves
  a_r2_fine_frozen: assert property (@(posedge fastClk) disable iff (rst)
    stop |=> $stable(valQ));
endmodule

// File: rtl/pixelTimerData.sv
`timescale 1ns/1ps
module pixelTimerData import pixelTimerPkg::*; #(
  parameter int COARSE_W = COARSE_W_D,
  parameter int TOT_W    = TOT_W_D,
  parameter int FINE_W   = FINE_W_D,
  parameter logic [COARSE_W-1:0] COARSE_TAPS = COARSE_TAPS_D,
  parameter logic [TOT_W-1:0]    TOT_TAPS    = TOT_TAPS_D
) (
  input  logic              clk,
  input  logic              rst,
  input  pxStrobe_t         strobe,
  input  logic [FINE_W-1:0] fineVal,
  output logic              serData
);
  localparam logic [COARSE_W-1:0] COARSE_SEED = COARSE_W'(1);
  localparam logic [TOT_W-1:0]    TOT_SEED    = TOT_W'(1);
  localparam logic [FINE_W-1:0]   FINE_SEED   = FINE_W'(1);
  // predecessor of the seed: the last state before the sequence wraps
  localparam logic [COARSE_W-1:0] COARSE_TERM = {
    COARSE_SEED[0] ^ (^(COARSE_SEED[COARSE_W-1:1] & COARSE_TAPS[COARSE_W-2:0])),
    COARSE_SEED[COARSE_W-1:1]};

  logic [COARSE_W-1:0] coarseQ;
  logic [TOT_W-1:0]    totQ;
  logic [FINE_W-1:0]   fineQ;
  logic [COARSE_W-1:0] coarseNext;
  logic [TOT_W-1:0]    totNext;

  assign coarseNext = {coarseQ[COARSE_W-2:0], ^(coarseQ & COARSE_TAPS)};
  assign totNext    = {totQ[TOT_W-2:0], ^(totQ & TOT_TAPS)};

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseQ <= COARSE_SEED;
      totQ    <= TOT_SEED;
      fineQ   <= FINE_SEED;
    end else if (strobe.shiftStep) begin
      {coarseQ, totQ, fineQ} <= {coarseQ, totQ, fineQ} << 1;
    end else begin
      fineQ <= fineVal;
      if (strobe.coarseStep || (strobe.countStep && coarseQ != COARSE_TERM))
        coarseQ <= coarseNext;
      if (strobe.totStep) totQ <= totNext;
    end
  end

  assign serData = coarseQ[COARSE_W-1];

  // R7: a count sitting at the terminal state stays there
  a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (strobe.countStep && coarseQ == COARSE_TERM) |=> (coarseQ == COARSE_TERM));
endmodule

// File: rtl/pixelTimerCtrl.sv
`timescale 1ns/1ps
module pixelTimerCtrl import pixelTimerPkg::*; #(
  parameter int WORD_W = 24
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  logic      trigger,
  input  logic      tokenIn,
  input  logic      cfgMask,
  input  logic      cfgCountMode,
  input  logic      fineStarted,
  output pxStrobe_t strobe,
  output logic      fineArm,
  output logic      fineStop,
  output logic      serValid,
  output logic      tokenOut
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  pxState_t         stateQ;
  logic             hitSeenQ, totDoneQ, hitQ, recordedQ;
  logic [CNT_W-1:0] bitCntQ;
  logic             acqLive, timeLive, firstSight;

  always_comb begin
    acqLive           = (stateQ == PX_ACQ) && !trigger && !cfgMask;
    timeLive          = acqLive && !cfgCountMode;
    firstSight        = timeLive && !hitSeenQ && (hit || fineStarted);
    strobe.coarseStep = timeLive && hitSeenQ;
    strobe.totStep    = timeLive && hitSeenQ && !totDoneQ && hit;
    strobe.countStep  = acqLive && cfgCountMode && hit && !hitQ;
    strobe.shiftStep  = (stateQ == PX_SHIFT);
  end

  assign fineArm  = (stateQ == PX_ACQ) && !cfgMask && !cfgCountMode;
  assign fineStop = hitSeenQ || (stateQ != PX_ACQ);
  assign serValid = (stateQ == PX_SHIFT);
  assign tokenOut = (stateQ == PX_PASSED);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= PX_ACQ;
      hitSeenQ  <= 1'b0;
      totDoneQ  <= 1'b0;
      hitQ      <= 1'b0;
      recordedQ <= 1'b0;
      bitCntQ   <= '0;
    end else begin
      hitQ      <= hit;
      recordedQ <= recordedQ | firstSight | strobe.countStep;
      if (firstSight) hitSeenQ <= 1'b1;
      if (timeLive && hitSeenQ && !hit) totDoneQ <= 1'b1;
      case (stateQ)
        PX_ACQ:  if (trigger) stateQ <= PX_HELD;
        PX_HELD: if (tokenIn) begin
          stateQ  <= recordedQ ? PX_SHIFT : PX_PASSED;
          bitCntQ <= '0;
        end
        PX_SHIFT: begin
          bitCntQ <= bitCntQ + 1'b1;
          if (bitCntQ == LAST_BIT) stateQ <= PX_PASSED;
        end
        default: stateQ <= PX_PASSED;
      endcase
    end
  end

  // R5: a trigger edge never lets a first hit be recorded
  a_r5_trigger_wins: assert property (@(posedge clk) disable iff (rst)
    (stateQ == PX_ACQ && trigger && !hitSeenQ) |=> !hitSeenQ);
  // R9, R10: the token only moves on after it was offered
  a_r9_token_offered: assert property (@(posedge clk) disable iff (rst)
    $rose(tokenOut) |-> $past(tokenIn));
  // R9: the end of a serial word hands the token on
  a_r9_word_then_token: assert property (@(posedge clk) disable iff (rst)
    $fell(serValid) |-> tokenOut);
  // R12: acquisition is never re-entered without reset
  a_r12_no_reacquire: assert property (@(posedge clk) disable iff (rst)
    (stateQ != PX_ACQ) |=> (stateQ != PX_ACQ));
endmodule

// File: rtl/pixelHitTimer.sv
`timescale 1ns/1ps
module pixelHitTimer import pixelTimerPkg::*; #(
  parameter int COARSE_W = COARSE_W_D,
  parameter int TOT_W    = TOT_W_D,
  parameter int FINE_W   = FINE_W_D,
  parameter logic [COARSE_W-1:0] COARSE_TAPS = COARSE_TAPS_D,
  parameter logic [TOT_W-1:0]    TOT_TAPS    = TOT_TAPS_D,
  parameter logic [FINE_W-1:0]   FINE_TAPS   = FINE_TAPS_D
) (
  input  logic clk,
  input  logic fastClk,
  input  logic rst,
  input  logic hit,
  input  logic trigger,
  input  logic tokenIn,
  input  logic cfgMask,
  input  logic cfgCountMode,
  output logic serData,
  output logic serValid,
  output logic tokenOut
);
  localparam int WORD_W = COARSE_W + TOT_W + FINE_W;

  pxStrobe_t         strobe;
  logic              fineArm, fineStop, fineStarted;
  logic [FINE_W-1:0] fineVal;

  pixelFineCounter #(.FINE_W(FINE_W), .FINE_TAPS(FINE_TAPS)) uFine (
    .fastClk(fastClk), .rst(rst), .hit(hit), .arm(fineArm), .stop(fineStop),
    .started(fineStarted), .value(fineVal));

  pixelTimerCtrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst(rst), .hit(hit), .trigger(trigger), .tokenIn(tokenIn),
    .cfgMask(cfgMask), .cfgCountMode(cfgCountMode), .fineStarted(fineStarted),
    .strobe(strobe), .fineArm(fineArm), .fineStop(fineStop),
    .serValid(serValid), .tokenOut(tokenOut));

  pixelTimerData #(.COARSE_W(COARSE_W), .TOT_W(TOT_W), .FINE_W(FINE_W),
                   .COARSE_TAPS(COARSE_TAPS), .TOT_TAPS(TOT_TAPS)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .fineVal(fineVal), .serData(serData));
endmodule

// File: tb/tb_pixelHitTimer.sv
`timescale 1ns/1ps
module tb_pixelHitTimer;
  logic clk = 1'b0, fastClk = 1'b0;
  logic rst = 1'b1, hit = 1'b0, trigger = 1'b0, tokenIn = 1'b0;
  logic cfgMask = 1'b0, cfgCountMode = 1'b0;
  logic serData, serValid, tokenOut;
  int   nRun = 0, nFail = 0;

  pixelHitTimer dut (.clk(clk), .fastClk(fastClk), .rst(rst), .hit(hit),
    .trigger(trigger), .tokenIn(tokenIn), .cfgMask(cfgMask),
    .cfgCountMode(cfgCountMode), .serData(serData), .serValid(serValid),
    .tokenOut(tokenOut));

  always #4 clk = ~clk;
  initial begin
    #0.1;
    forever begin fastClk = 1'b1; #0.25; fastClk = 1'b0; #0.25; end
  end

  // vectors: hit delay after an edge (ps), hit length H, trigger offset K,
  // expected fine, ToT and coarse step counts
  localparam int NV = 7;
  localparam int V_D [NV]   = '{300, 50, 7800, 3800, 5300, 1300, 7800};
  localparam int V_H [NV]   = '{3, 1, 2, 6, 2, 10, 1};
  localparam int V_K [NV]   = '{5, 1, 3, 4, 20, 10, 1};
  localparam int V_F [NV]   = '{14, 15, 0, 7, 4, 12, 0};
  localparam int V_T [NV]   = '{2, 0, 1, 3, 1, 9, 0};
  localparam int V_C [NV]   = '{4, 0, 2, 3, 19, 9, 0};

  function automatic logic [11:0] adv(input logic [11:0] s, input int w,
                                      input logic [11:0] taps, input int n);
    logic [11:0] mask = 12'((1 << w) - 1);
    for (int i = 0; i < n; i++) s = ((s << 1) | 12'(^(s & taps))) & mask;
    return s;
  endfunction

  function automatic logic [23:0] expWord(input int c, input int t, input int f);
    logic [11:0] cv = adv(12'd1, 12, 12'h829, c);
    logic [11:0] tv = adv(12'd1, 8, 12'h0B8, t);
    logic [11:0] fv = adv(12'd1, 4, 12'h00C, f);
    return {cv, tv[7:0], fv[3:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; hit = 1'b0; trigger = 1'b0; tokenIn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fireTrigger();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic pulseHits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hit = 1'b1;
      @(negedge clk); hit = 1'b0;
    end
  endtask

  task automatic readWord(output logic [23:0] word, output int nBits, output int cycles);
    word = '0; nBits = 0; cycles = 0;
    repeat (2) @(negedge clk);
    tokenIn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cycles++;
      if (serValid) begin word = {word[22:0], serData}; nBits++; end
      if (tokenOut) break;
    end
    tokenIn = 1'b0;
  endtask

  task automatic runTime(input int dPs, input int h, input int k);
    @(posedge clk);
    fork
      begin #(real'(dPs) / 1000.0); hit = 1'b1; #(8.0 * h); hit = 1'b0; end
      begin #(8.0 * k + 4.0); trigger = 1'b1; #8; trigger = 1'b0; end
    join
  endtask

  task automatic expectWord(input string req, input logic [23:0] exp);
    logic [23:0] w; int nb, cy;
    readWord(w, nb, cy);
    check(nb == 24, {req, " R9 bit count"}, nb, 24);
    check(w == exp, {req, " R9 word"}, w, exp);
    check(cy == 25 && tokenOut, {req, " R9 token after word"}, cy, 25);
  endtask

  task automatic expectEmpty(input string req);
    logic [23:0] w; int nb, cy;
    readWord(w, nb, cy);
    check(nb == 0, {req, " R10 no bits"}, nb, 0);
    check(cy == 1 && tokenOut, {req, " R10 immediate token"}, cy, 1);
  endtask

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tokenOut && !serValid, "R1 reset outputs", {tokenOut, serValid}, 0);

    // R11: token offered during acquisition is ignored
    tokenIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!tokenOut && !serValid, "R11 early token", {tokenOut, serValid}, 0);
    end
    tokenIn = 1'b0;

    // table walk: R2 fine, R4 ToT, R3 coarse; last entry is the R1 seed word
    for (int v = 0; v < NV; v++) begin
      doReset();
      runTime(V_D[v], V_H[v], V_K[v]);
      expectWord(v == NV - 1 ? "R1 seed" : "R2 R3 R4 vector",
                 expWord(V_C[v], V_T[v], V_F[v]));
    end

    // R5: hit first seen on the trigger edge, late in the period
    doReset();
    @(posedge clk);
    fork
      begin #7.8; hit = 1'b1; #16; hit = 1'b0; end
      begin #4; trigger = 1'b1; #8; trigger = 1'b0; end
    join
    expectEmpty("R5 late hit");
    // R5: fast counter already running when the trigger edge arrives
    doReset();
    @(posedge clk);
    fork
      begin #3.0; hit = 1'b1; #16; hit = 1'b0; end
      begin #4; trigger = 1'b1; #8; trigger = 1'b0; end
    join
    expectEmpty("R5 early hit");

    // R13: a second hit before the trigger changes nothing
    doReset();
    @(posedge clk);
    fork
      begin #0.3; hit = 1'b1; #16; hit = 1'b0; #24; hit = 1'b1; #24; hit = 1'b0; end
      begin #52; trigger = 1'b1; #8; trigger = 1'b0; end
    join
    expectWord("R13 second hit", expWord(5, 1, 14));

    // R12: hit only after the trigger
    doReset();
    fireTrigger();
    @(negedge clk); hit = 1'b1;
    repeat (3) @(negedge clk); hit = 1'b0;
    expectEmpty("R12 hit after trigger");

    // R8: masked in time mode and in counting mode
    doReset();
    cfgMask = 1'b1;
    runTime(300, 3, 5);
    expectEmpty("R8 masked time");
    doReset();
    cfgCountMode = 1'b1;
    pulseHits(3);
    fireTrigger();
    expectEmpty("R8 masked count");
    cfgMask = 1'b0;

    // R6 counting, with R12 hits after the trigger and during read-out
    doReset();
    pulseHits(5);
    fireTrigger();
    pulseHits(2);
    fork
      expectWord("R6 R12 count five", expWord(5, 0, 0));
      begin
        for (int i = 0; i < 14; i++) begin @(negedge clk); hit = ~hit; end
        hit = 1'b0;
      end
    join

    // R6: counting mode with no hits
    doReset();
    fireTrigger();
    expectEmpty("R6 zero count");

    // R7: saturation
    doReset();
    pulseHits(4100);
    fireTrigger();
    expectWord("R7 saturated", expWord(4094, 0, 0));
    check(expWord(4094, 0, 0) == 24'h800011, "R7 terminal value", expWord(4094, 0, 0), 24'h800011);
    cfgCountMode = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule